// File: doc/BRIEF.md
# Aliased-Address Word Copy Engine

This block sits on a 32-bit register bus and holds 64 general-purpose 32-bit registers. Three of them steer a copy engine: word 12 (byte offset 0x30) holds a source address, word 13 (0x34) a destination address, and word 14 (0x38) a control word. The control word carries a word count in bits 23:0 and a start request in bit 24. Software loads the two addresses and then writes the control word with bit 24 set.

On that write the engine decides the direction from which address lies at or above 0x7000_0000, the host alias window. It rebases the host-side address into the host's local space and the module-side address into the module memory's local space. It then copies one 32-bit word per cycle between a host memory port and a module memory port, reading on one and writing on the other. It also raises a flag when the address pair is one of the two recognised combinations.

Top module: `alias_dma_engine`

## Requirements
- R1: Every one of the 64 registers, selected by a 6-bit word index, reads back on `reg_rdata` the last value written to it. The only exception is bit 24 of word 14, which always reads 0.
- R2: A write to word 14 with bit 24 set, made while idle, is accepted as a start. The stored control word keeps bits 23:0 and other bits, with bit 24 cleared.
- R3: If the source is at or above 0x7000_0000, the copy reads the host port and writes the module port (`host_we`=0, `mod_we`=1). Otherwise, if the destination is at or above 0x7000_0000, it reads the module port and writes the host port (`host_we`=1, `mod_we`=0).
- R4: A host-side address is rebased as follows. Subtract 0x7000_0000. Then add 0x0800_0000 if bit 27 of the difference is 1, or add 0x0C00_0000 if it is 0.
- R5: The module-side address is rebased by subtracting 0x1000_0000.
- R6: At each accepted start, `supported` is set to 1 in either of two cases: the source's top byte is 0x78 and the destination's top nibble is 0x1, or the source's top nibble is 0x1 and the destination's top byte is 0x70. In every other case it is set to 0.
- R7: If neither address is at or above 0x7000_0000, a start copies nothing, leaves `busy` low and sets `err`. Any accepted start re-evaluates `err`.
- R8: Word i of the copy uses address base+4·i on both ports. Its write data is the read data of the same cycle. A word moves only in a cycle where `busy`, `host_rdy` and `mod_rdy` are all high.
- R9: `busy` rises the cycle after acceptance and falls after the last word moves. `done` pulses for one cycle as `busy` falls. A zero count gives a `done` pulse with no `busy` and no memory writes.
- R10: While `busy` is high, writes to word 14 are ignored: the register keeps its value and no new start happens.
- R11: After reset all registers read 0, and `busy`, `done`, `err` and `supported` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| host_req | output | 1 | Host port access request |
| host_we | output | 1 | Host port write enable |
| host_addr | output | 32 | Host port byte address |
| host_wdata | output | 32 | Host port write data |
| host_rdata | input | 32 | Host port read data, same cycle |
| host_rdy | input | 1 | Host port ready |
| mod_req | output | 1 | Module port access request |
| mod_we | output | 1 | Module port write enable |
| mod_addr | output | 32 | Module port byte address |
| mod_wdata | output | 32 | Module port write data |
| mod_rdata | input | 32 | Module port read data, same cycle |
| mod_rdy | input | 1 | Module port ready |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start had no aliased address |
| supported | output | 1 | Last start used a recognised address pair |

## Verification
Some properties are checked on every cycle:
- Addresses advance by four after each moved word.
- Addresses and `busy` hold while either port stalls.
- The control word is frozen during a copy.
- `done` coincides with the fall of `busy`.
- `err` never overlaps `busy`.

Other behaviour only the bench's scenarios can show. This includes the rebasing arithmetic for both values of bit 27, the choice of direction (including the case where both addresses are aliased), the `supported` decode, the zero-count case and the exact data moved. The bench shows these by comparing every write against a queue of expected writes.

// File: rtl/alias_dma_engine.sv
module alias_dma_engine #(
  parameter int          NREG       = 64,
  parameter int          LEN_W      = 24,
  parameter int          START_BIT  = 24,
  parameter int          SRC_IDX    = 12,
  parameter int          DST_IDX    = 13,
  parameter int          CTL_IDX    = 14,
  parameter logic [31:0] ALIAS_BASE = 32'h7000_0000,
  parameter logic [31:0] MOD_BASE   = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        host_req,
  output logic        host_we,
  output logic [31:0] host_addr,
  output logic [31:0] host_wdata,
  input  logic [31:0] host_rdata,
  input  logic        host_rdy,
  output logic        mod_req,
  output logic        mod_we,
  output logic [31:0] mod_addr,
  output logic [31:0] mod_wdata,
  input  logic [31:0] mod_rdata,
  input  logic        mod_rdy,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        supported
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [31:0] START_MASK = 32'h1 << START_BIT;

  logic [31:0]      regs [NREG];
  logic             to_host;
  logic [31:0]      hptr, mptr;
  logic [LEN_W-1:0] remain;

  function automatic logic [31:0] host_rebase(input logic [31:0] a);
    logic [31:0] t;
    t = a - ALIAS_BASE;
    return t + (t[27] ? 32'h0800_0000 : 32'h0C00_0000);
  endfunction

  wire [IDX_W-1:0] idx     = reg_idx[IDX_W-1:0];
  wire [31:0]      src     = regs[SRC_IDX];
  wire [31:0]      dst     = regs[DST_IDX];
  wire             src_hi  = src >= ALIAS_BASE;
  wire             dst_hi  = dst >= ALIAS_BASE;
  wire             ctl_hit = reg_we && (idx == IDX_W'(CTL_IDX));
  wire             go      = ctl_hit && !busy && reg_wdata[START_BIT];
  wire             beat    = busy && host_rdy && mod_rdy;
  wire             pair_ok = (src[31:24] == 8'h78 && dst[31:28] == 4'h1) ||
                             (src[31:28] == 4'h1 && dst[31:24] == 8'h70);

  assign reg_rdata  = regs[idx];
  assign host_req   = busy;
  assign mod_req    = busy;
  assign host_we    = busy && to_host;
  assign mod_we     = busy && !to_host;
  assign host_addr  = hptr;
  assign mod_addr   = mptr;
  assign host_wdata = mod_rdata;
  assign mod_wdata  = host_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      supported <= 1'b0;
      to_host   <= 1'b0;
      hptr      <= '0;
      mptr      <= '0;
      remain    <= '0;
    end else begin
      done <= 1'b0;
      if (reg_we && !(ctl_hit && busy))
        regs[idx] <= (idx == IDX_W'(CTL_IDX)) ? (reg_wdata & ~START_MASK) : reg_wdata;
      if (go) begin
        supported <= pair_ok;
        err       <= !(src_hi || dst_hi);
        if (src_hi || dst_hi) begin
          to_host <= !src_hi;
          hptr    <= src_hi ? host_rebase(src) : host_rebase(dst);
          mptr    <= src_hi ? dst - MOD_BASE : src - MOD_BASE;
          remain  <= reg_wdata[LEN_W-1:0];
          if (reg_wdata[LEN_W-1:0] == '0) done <= 1'b1;
          else                            busy <= 1'b1;
        end
      end else if (beat) begin
        hptr   <= hptr + 32'd4;
        mptr   <= mptr + 32'd4;
        remain <= remain - 1'b1;
        if (remain == LEN_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_hit) |=> $stable(regs[CTL_IDX]));
  // R9
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && busy && host_rdy && mod_rdy && remain != LEN_W'(1)) |=>
      (host_addr == $past(host_addr) + 32'd4 && mod_addr == $past(mod_addr) + 32'd4));
  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(host_rdy && mod_rdy)) |=> (busy && $stable(host_addr) && $stable(mod_addr)));
endmodule

// File: tb/alias_dma_engine_tb.sv
module alias_dma_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic host_req, host_we, mod_req, mod_we;
  logic [31:0] host_addr, host_wdata, host_rdata, mod_addr, mod_wdata, mod_rdata;
  logic host_rdy = 1'b1, mod_rdy = 1'b1;
  logic busy, done, err, supported;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int busy_cyc = 0, done_cnt = 0;
  bit stall_on = 0, hold_off = 0;

  typedef struct { bit to_host; logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] hfn(input logic [31:0] a); return a ^ 32'hC3C3_0000; endfunction
  function automatic logic [31:0] mfn(input logic [31:0] a); return {a[15:0], a[31:16]} ^ 32'h0000_9999; endfunction
  function automatic logic [31:0] xl(input logic [31:0] a);
    logic [31:0] t; t = a - 32'h7000_0000;
    return t[27] ? t + 32'h0800_0000 : t + 32'h0C00_0000;
  endfunction

  assign host_rdata = hfn(host_addr);
  assign mod_rdata  = mfn(mod_addr);

  alias_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy), .mod_req(mod_req),
    .mod_we(mod_we), .mod_addr(mod_addr), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata),
    .mod_rdy(mod_rdy), .busy(busy), .done(done), .err(err), .supported(supported));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    if (hold_off) begin host_rdy = 1'b0; mod_rdy = 1'b0; end
    else if (stall_on) begin host_rdy = (cyc % 3) != 0; mod_rdy = (cyc % 4) != 1; end
    else begin host_rdy = 1'b1; mod_rdy = 1'b1; end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (done) done_cnt++;
      if ((host_req || mod_req) && host_rdy && mod_rdy) begin
        wr_t act, e;
        act.to_host = host_we;
        act.a = host_we ? host_addr : mod_addr;
        act.d = host_we ? host_wdata : mod_wdata;
        if (exp_q.size() == 0) check("R8 unexpected write", act.a, 32'hFFFF_FFFF);
        else begin
          e = exp_q.pop_front();
          check("R3 direction", {31'd0, act.to_host}, {31'd0, e.to_host});
          check("R4/R5/R8 write address", act.a, e.a);
          check("R8 write data", act.d, e.d);
        end
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_idx = idx[5:0]; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(posedge clk); #2;
    reg_idx = idx[5:0];
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push_exp(input logic [31:0] s, input logic [31:0] t, input int len);
    for (int i = 0; i < len; i++) begin
      wr_t w;
      if (s >= 32'h7000_0000) begin
        w.to_host = 0; w.a = t - 32'h1000_0000 + 4*i; w.d = hfn(xl(s) + 4*i);
        exp_q.push_back(w);
      end else if (t >= 32'h7000_0000) begin
        w.to_host = 1; w.a = xl(t) + 4*i; w.d = mfn(s - 32'h1000_0000 + 4*i);
        exp_q.push_back(w);
      end
    end
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] t, input int len, input bit expect_run);
    wr(12, s); wr(13, t);
    push_exp(s, t, len);
    busy_cyc = 0; done_cnt = 0;
    wr(14, 32'h0100_0000 | len);
    for (int k = 0; k < 3000 && done_cnt == 0 && expect_run; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    check("R11 busy", {31'd0, busy}, 0);
    check("R11 done", {31'd0, done}, 0);
    check("R11 err", {31'd0, err}, 0);
    check("R11 supported", {31'd0, supported}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) begin rd(i, v); check("R11 reg reset", v, 0); end

    for (int i = 0; i < 64; i++)
      wr(i, (i == 14) ? 32'hA200_0000 | i : 32'h5A00_0000 + i * 32'h0101_0307);
    for (int i = 0; i < 64; i++) begin
      rd(i, v);
      check("R1 readback", v, (i == 14) ? 32'hA200_0000 | i : 32'h5A00_0000 + i * 32'h0101_0307);
    end
    check("R1 no start from plain write", {31'd0, busy}, 0);

    // host -> module, bit 27 set after subtract
    run(32'h7800_4000, 32'h1000_0000, 5, 1);
    check("R9 busy cycles", busy_cyc, 5);
    check("R9 done pulses", done_cnt, 1);
    check("R6 supported 0x78/0x1", {31'd0, supported}, 1);
    check("R7 err clear", {31'd0, err}, 0);
    rd(14, v); check("R2 start bit cleared", v, 32'h0000_0005);

    // module -> host, bit 27 clear, with stalls
    stall_on = 1;
    run(32'h1000_0100, 32'h7090_0000, 6, 1);
    stall_on = 0;
    check("R9 done pulses stalled", done_cnt, 1);
    check("R6 supported 0x1/0x70", {31'd0, supported}, 1);

    // unsupported pair but aliased source
    run(32'h7A00_0000, 32'h2000_0000, 3, 1);
    check("R6 unsupported", {31'd0, supported}, 0);
    check("R9 busy cycles 3", busy_cyc, 3);

    // both aliased: source wins
    run(32'h7800_0010, 32'h7000_0020, 2, 1);
    check("R3 src priority supported", {31'd0, supported}, 0);

    // neither aliased
    run(32'h2000_0000, 32'h3000_0000, 4, 0);
    check("R7 err set", {31'd0, err}, 1);
    check("R7 no busy", busy_cyc, 0);
    check("R7 no done", done_cnt, 0);
    check("R6 unsupported on err", {31'd0, supported}, 0);

    // zero count
    run(32'h1000_0000, 32'h7000_0000, 0, 1);
    check("R9 zero count done", done_cnt, 1);
    check("R9 zero count no busy", busy_cyc, 0);
    check("R7 err cleared by start", {31'd0, err}, 0);

    // control write while busy
    hold_off = 1;
    wr(12, 32'h7800_0000); wr(13, 32'h1000_0400);
    push_exp(32'h7800_0000, 32'h1000_0400, 8);
    busy_cyc = 0; done_cnt = 0;
    wr(14, 32'h0100_0008);
    wr(14, 32'h0100_0003);
    rd(14, v); check("R10 ctl held while busy", v, 32'h0000_0008);
    check("R10 still busy", {31'd0, busy}, 1);
    hold_off = 0;
    for (int k = 0; k < 3000 && done_cnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R10 original count used", done_cnt, 1);

    check("R8 all writes seen", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule